// File: doc/BRIEF.md
# Prescaled Fractional Baud Generator

This block derives the sampling and bit-rate strobes for one serial channel from a single reference clock. The reference first passes through a prescaler that divides by one or by four. A divider with a 16-bit integer part and a 4-bit fractional part follows it. The fraction is a phase accumulator: on the right share of periods it stretches the period by one prescaled clock, so the average tick period is exactly the integer plus the fraction over sixteen. Last comes an oversampling counter that turns every 16th sample tick (16X mode) or every 4th (4X mode) into a bit-rate strobe. In 4X mode with a divisor of one and no prescaling, the bit rate reaches one quarter of the reference clock.

A strap input gives the prescaler setting while reset is held. Software can override it later through a mode register. All configuration arrives through a plain single-cycle write port: `cfg_we` with an address and a byte. It has no handshake, because a write always completes in the cycle it is presented. The two outputs are one-cycle enables in the reference clock domain and carry no data, so no valid/ready flow applies at any edge of the block. Register map:

| Address | Contents |
|---|---|
| 0 | divisor bits 7:0 |
| 1 | divisor bits 15:8 |
| 2 | fraction in bits 3:0 |
| 3 | mode: bit 7 set selects divide-by-4, bit 0 set selects 4X |

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), the prescaler setting is loaded from `quad_strap` (1 = divide by 4). Divisor and fraction clear to 0, the mode is 16X, and neither output pulses after reset until a divisor is written.
- R2: With divide-by-1 the prescaled clock advances on every reference cycle. With divide-by-4 it advances on every 4th reference cycle, the first being the 4th cycle after a restart.
- R3: A write to address 3 sets the prescaler from data bit 7 (1 = divide by 4, 0 = divide by 1), replacing the strap value.
- R4: With fraction 0 and divisor N, `sample_en` pulses once every N prescaled clocks, the first pulse on the Nth prescaled clock after a restart.
- R5: With divisor N and fraction F, the m-th sample pulse after a restart falls on prescaled clock m·N + floor((m−1)·F/16), so every 16 consecutive pulses span exactly 16·N + F prescaled clocks.
- R6: A divisor of 0 keeps both `sample_en` and `bit_en` low.
- R7: Any register write clears the prescaler, divider, fraction accumulator and oversampling counter, and counting restarts from zero in the next cycle with the new settings.
- R8: Mode bit 0 selects 16X (0) or 4X (1). `bit_en` pulses together with every 16th or every 4th `sample_en` after a restart, and never without `sample_en`.
- R9: With divide-by-1, divisor 1, fraction 0 and 4X mode, `bit_en` pulses on every 4th reference cycle, one quarter of the reference rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quad_strap | input | 1 | Prescaler setting loaded during reset (1 = divide by 4) |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| sample_en | output | 1 | One-cycle oversampling tick |
| bit_en | output | 1 | One-cycle bit-rate tick |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, a 4-bit fraction, a prescale ratio of 4 and oversampling ratios of 16 and 4. These defaults exercise a divisor that needs its upper byte (258), fractions of 0, 3, 5 and 15, both strap levels and the register override of the prescaler. They also cover the quarter-rate corner with divisor 1 in 4X mode. A restart in the middle of a count shows that a rewrite of the same divisor still restarts counting. Long runs compare the pulse count since each restart with the closed-form integer-plus-fraction tick schedule.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  typedef enum logic [1:0] {
    REG_DIV_LO = 2'd0,
    REG_DIV_HI = 2'd1,
    REG_FRAC   = 2'd2,
    REG_MODE   = 2'd3
  } cfg_reg_e;

  localparam int MODE_QUAD_BIT = 7;
  localparam int MODE_X4_BIT   = 0;
endpackage

// File: rtl/bfg_regs.sv
module bfg_regs
  import bfg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quad_strap,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [DIV_W-1:0]  div_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              quad_o,
  output logic              x4_o,
  output logic              restart_o
);
  localparam int HI_W = DIV_W - 8;

  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic              quad_q;
  logic              x4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      frac_q <= '0;
      quad_q <= quad_strap;
      x4_q   <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_reg_e'(cfg_addr))
        REG_DIV_LO: div_q[7:0]       <= cfg_wdata;
        REG_DIV_HI: div_q[DIV_W-1:8] <= cfg_wdata[HI_W-1:0];
        REG_FRAC:   frac_q           <= cfg_wdata[FRAC_W-1:0];
        default: begin
          quad_q <= cfg_wdata[MODE_QUAD_BIT];
          x4_q   <= cfg_wdata[MODE_X4_BIT];
        end
      endcase
    end
  end

  assign div_o     = div_q;
  assign frac_o    = frac_q;
  assign quad_o    = quad_q;
  assign x4_o      = x4_q;
  assign restart_o = cfg_we;

  // R3
  quad_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd3) |=> (quad_q == $past(cfg_wdata[MODE_QUAD_BIT])));

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(div_q) && $stable(frac_q) && $stable(quad_q)));
endmodule

// File: rtl/bfg_presc.sv
module bfg_presc #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic quad_i,
  output logic en_o
);
  localparam int CW = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (quad_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign en_o = quad_i ? (cnt_q == LAST) : 1'b1;

  // R2
  quad_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_i && en_o && !clr_i) |=> !en_o);
endmodule

// File: rtl/bfg_fdiv.sv
module bfg_fdiv #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  logic [DIV_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              extra_q;
  logic [DIV_W:0]    limit;
  logic [FRAC_W:0]   acc_sum;
  logic              hit;
  logic              live;

  assign limit   = {1'b0, div_i} - (DIV_W+1)'(1) + {{DIV_W{1'b0}}, extra_q};
  assign hit     = ({1'b0, cnt_q} == limit);
  assign live    = (div_i != '0);
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
  assign tick_o  = en_i && hit && live;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (en_i && live) begin
      if (hit) begin
        cnt_q   <= '0;
        acc_q   <= acc_sum[FRAC_W-1:0];
        extra_q <= acc_sum[FRAC_W];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i == '0) |-> !tick_o);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_i);

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && acc_q == '0 && !extra_q));

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i > DIV_W'(1) && !clr_i) |=> !tick_o);
endmodule

// File: rtl/bfg_osr.sv
module bfg_osr #(
  parameter int HI = 16,
  parameter int LO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  input  logic x4_i,
  output logic bit_o
);
  localparam int CW = $clog2(HI);
  localparam logic [CW-1:0] LAST_HI = CW'(HI - 1);
  localparam logic [CW-1:0] LAST_LO = CW'(LO - 1);

  logic [CW-1:0] os_q;
  logic [CW-1:0] last;

  assign last  = x4_i ? LAST_LO : LAST_HI;
  assign bit_o = tick_i && (os_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      os_q <= '0;
    end else if (tick_i) begin
      os_q <= (os_q == last) ? '0 : os_q + 1'b1;
    end
  end

  // R8
  os_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_q <= last);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DIV_W     = 16,
  parameter int FRAC_W    = 4,
  parameter int PRE_RATIO = 4,
  parameter int OSR_HI    = 16,
  parameter int OSR_LO    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quad_strap,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic       sample_en,
  output logic       bit_en
);
  logic [DIV_W-1:0]  div_w;
  logic [FRAC_W-1:0] frac_w;
  logic              quad_w;
  logic              x4_w;
  logic              restart_w;
  logic              pre_en_w;

  bfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .quad_strap(quad_strap),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .div_o(div_w), .frac_o(frac_w), .quad_o(quad_w), .x4_o(x4_w),
    .restart_o(restart_w)
  );

  bfg_presc #(.RATIO(PRE_RATIO)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr_i(restart_w), .quad_i(quad_w),
    .en_o(pre_en_w)
  );

  bfg_fdiv #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_fdiv (
    .clk(clk), .rst_n(rst_n), .clr_i(restart_w), .en_i(pre_en_w),
    .div_i(div_w), .frac_i(frac_w), .tick_o(sample_en)
  );

  bfg_osr #(.HI(OSR_HI), .LO(OSR_LO)) u_osr (
    .clk(clk), .rst_n(rst_n), .clr_i(restart_w), .tick_i(sample_en),
    .x4_i(x4_w), .bit_o(bit_en)
  );

  // R8
  bit_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> sample_en);
endmodule

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       quad_strap = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       sample_en;
  logic       bit_en;

  always #2.5 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .quad_strap(quad_strap),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sample_en(sample_en), .bit_en(bit_en)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  int  mN = 0, mF = 0;
  bit  mquad = 0, mx4 = 0;
  int  c = 1, pcount = 0, m = 1, ntick = 0, dut_ticks = 0;
  bit  pend = 0, in_reset = 1;

  task automatic step();
    bit pre, exp_s, exp_b;
    int pn, ratio;
    @(negedge clk);
    if (pend) begin
      c = 1; pcount = 0; m = 1; ntick = 0; dut_ticks = 0; pend = 0;
    end
    pre   = mquad ? (c % 4 == 0) : 1'b1;
    pn    = pcount + (pre ? 1 : 0);
    exp_s = (mN != 0) && pre && (pn == mN * m + ((m - 1) * mF) / 16);
    ratio = mx4 ? 4 : 16;
    exp_b = exp_s && (ntick % ratio == ratio - 1);
    if (!in_reset) begin
      checks++;
      if (sample_en !== exp_s || bit_en !== exp_b) begin
        errors++;
        $display("FAIL %s cycle %0d: sample_en=%0b bit_en=%0b expected %0b %0b",
                 tag, c, sample_en, bit_en, exp_s, exp_b);
      end
    end
    c++;
    pcount = pn;
    if (exp_s) begin m++; ntick++; end
    if (sample_en === 1'b1) dut_ticks++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    case (a)
      0: mN = (mN & 'hff00) | d;
      1: mN = (mN & 'h00ff) | (d << 8);
      2: mF = d & 15;
      default: begin mquad = d[7]; mx4 = d[0]; end
    endcase
    pend = 1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_reset(input bit pin);
    in_reset = 1; rst_n = 1'b0; quad_strap = pin;
    run(3);
    mN = 0; mF = 0; mquad = pin; mx4 = 0;
    pend = 1; in_reset = 0;
    step();
    rst_n = 1'b1;
  endtask

  // closed-form count of pulses since the last restart
  task automatic chk_count(input string t);
    int k;
    k = 0;
    while (mN != 0 && mN * (k + 1) + (k * mF) / 16 <= pcount) k++;
    checks++;
    if (dut_ticks != k) begin
      errors++;
      $display("FAIL %s tick count: got %0d expected %0d", t, dut_ticks, k);
    end
  endtask

  initial begin
    // R1: strap high, no divisor -> silent
    tag = "R1";
    do_reset(1'b1);
    run(50);
    chk_count("R1");
    // R2/R4: strap divide-by-4, integer divisor 3
    tag = "R2";
    wr(0, 3);
    run(400);
    chk_count("R4");
    // R5: fraction 5
    tag = "R5";
    wr(2, 5);
    run(2000);
    chk_count("R5");
    // R3/R8: override to divide-by-1, 4X
    tag = "R3";
    wr(3, 8'h01);
    run(600);
    chk_count("R3");
    // R8: back to 16X, divide-by-4 via register
    tag = "R8";
    wr(3, 8'h80);
    run(1500);
    chk_count("R8");
    // R9: quarter rate
    tag = "R9";
    wr(2, 0);
    wr(0, 1);
    wr(3, 8'h01);
    run(200);
    chk_count("R9");
    // upper divisor byte: 258 + 3/16, divide-by-1, 16X
    tag = "R5";
    wr(3, 8'h00);
    wr(1, 1);
    wr(0, 2);
    wr(2, 3);
    run(4000);
    chk_count("R5");
    // R6: zero divisor
    tag = "R6";
    wr(1, 0);
    wr(0, 0);
    run(300);
    chk_count("R6");
    // R7: restart mid count with the same divisor
    tag = "R7";
    wr(0, 10);
    run(7);
    wr(0, 10);
    run(300);
    chk_count("R7");
    // R1: strap low -> divide-by-1, divisor 2, fraction 15
    tag = "R1";
    do_reset(1'b0);
    run(20);
    chk_count("R1");
    wr(0, 2);
    wr(2, 15);
    tag = "R5";
    run(2000);
    chk_count("R5");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule